// File: doc/BRIEF.md
# Descriptor access-rights check unit

This unit performs the load-access-rights operation of a segmented CPU that runs in protected mode. A request carries a 16-bit segment selector, the current privilege level, an operand-size flag and a protected-mode flag. The unit also samples the base and limit of the global and local descriptor tables. It first tests the mode, the null selector and the table limit, and none of these tests reads memory. If all three pass, it fetches the upper doubleword of the 8-byte descriptor through a request/valid handshake.

The fetched doubleword is tested for descriptor-type validity and for privilege. The result is one zero-flag outcome and, on success, a masked access-rights value with a write enable for the destination register. If the unit is not in protected mode, it raises an undefined-opcode error and produces no result.

Top module: `desc_rights_unit`

## Requirements
- R1: After reset, `done`, `zf`, `wr_en`, `ud_err`, `mem_req` and `busy` are all 0.
- R2: A request made with `prot_mode`=0 finishes with `done`=1 and `ud_err`=1, and with `zf`=0, `wr_en`=0 and `rights`=0. It issues no memory request.
- R3: A selector whose index (bits 15:3) is 0 and whose table bit (bit 2) is 0 fails with `zf`=0 and no memory request. Its `done` pulse comes two cycles after the cycle that accepted `start`.
- R4: The table bit picks the table: 0 selects the global table and 1 selects the local table. If index*8+7 exceeds that table's limit, the request fails with no memory read. Otherwise exactly one read is made, at table base + index*8 + 4.
- R5: A descriptor whose S bit (bit 12 of the fetched doubleword) is 1 always passes the type test. When S is 0, the type in bits 11:8 passes only for the values 1, 2, 3, 4, 5, 9, 0xB and 0xC.
- R6: A descriptor is conforming code when S is 1 and type bits 11 and 10 are both 1. Any descriptor that is not conforming code fails if the CPL is greater than its DPL (bits 14:13) or if the selector's RPL (bits 1:0) is greater than that DPL. Conforming code skips this test.
- R7: On success with `op32`=1, `rights` equals the fetched doubleword ANDed with 0x00F0FF00. This leaves out the limit nibble in bits 19:16.
- R8: On success with `op32`=0, `rights` equals the fetched doubleword ANDed with 0x0000FF00.
- R9: On success, `zf`=1 and `wr_en`=1 during the `done` cycle. On any failure, `zf`=0, `wr_en`=0 and `rights`=0. Outside `done`, `zf` and `wr_en` are 0.
- R10: `mem_req` stays high with a stable `mem_addr` until `mem_valid` arrives. `done` is a single-cycle pulse in the cycle after `mem_valid` is sampled. A `start` that arrives while `busy`=1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| sel | input | 16 | Segment selector |
| cpl | input | 2 | Current privilege level |
| op32 | input | 1 | 1 = 32-bit operand size, 0 = 16-bit |
| prot_mode | input | 1 | 1 = protected mode |
| gdt_base | input | AW | Global table base address |
| gdt_limit | input | LW | Global table byte limit |
| ldt_base | input | AW | Local table base address |
| ldt_limit | input | LW | Local table byte limit |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | AW | Address of the descriptor's upper doubleword |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| zf | output | 1 | Zero-flag result |
| wr_en | output | 1 | Destination register write enable |
| rights | output | 32 | Masked access rights |
| ud_err | output | 1 | Not-protected-mode error, valid with `done` |

## Verification
Selector patterns sweep the index across both tables and past each table's limit. These patterns separate the null case from local index 0, separate an in-range last entry from the first out-of-range one, and confirm the read address for each table. A full sweep of type, S bit, DPL, CPL, RPL and operand size against descriptors whose limit nibble and base bytes are non-zero separates type validity from privilege failures and from the conforming-code bypass. It also checks each mask. Requests outside protected mode, varied memory latencies and a `start` issued mid-fetch separate the error path, the handshake timing and the idle-only acceptance.

// File: rtl/dru_pkg.sv
package dru_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FETCH,
        ST_EVAL,
        ST_DONE
    } dru_state_e;

    typedef struct packed {
        logic [12:0] index;
        logic        ti;
        logic [1:0]  rpl;
    } dru_sel_t;

    typedef struct packed {
        logic [7:0] base_hi;
        logic       gran;
        logic       dflt;
        logic       rsv;
        logic       avl;
        logic [3:0] lim_hi;
        logic       present;
        logic [1:0] dpl;
        logic       s;
        logic [3:0] kind;
        logic [7:0] base_mid;
    } dru_hidw_t;

    localparam logic [31:0] RIGHTS_MASK_32 = 32'h00F0_FF00;
    localparam logic [31:0] RIGHTS_MASK_16 = 32'h0000_FF00;

    function automatic logic sys_kind_ok(input logic [3:0] kind);
        case (kind)
            4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h9, 4'hB, 4'hC: sys_kind_ok = 1'b1;
            default:                                         sys_kind_ok = 1'b0;
        endcase
    endfunction

    function automatic logic is_conforming(input dru_hidw_t d);
        is_conforming = d.s && d.kind[3] && d.kind[2];
    endfunction

endpackage

// File: rtl/dru_sel_decode.sv
module dru_sel_decode
    import dru_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  dru_sel_t          sel,
    input  logic [AW-1:0]     gdt_base,
    input  logic [LW-1:0]     gdt_limit,
    input  logic [AW-1:0]     ldt_base,
    input  logic [LW-1:0]     ldt_limit,
    output logic              is_null,
    output logic              in_limit,
    output logic [AW-1:0]     hi_addr
);
    localparam int CW = ((LW > 16) ? LW : 16) + 1;

    logic [CW-1:0] last_byte;
    logic [CW-1:0] lim_ext;
    logic [AW-1:0] base_sel;

    always_comb begin
        base_sel  = sel.ti ? ldt_base : gdt_base;
        lim_ext   = sel.ti ? CW'(ldt_limit) : CW'(gdt_limit);
        last_byte = CW'({sel.index, 3'b111});
        is_null   = (sel.index == '0) && !sel.ti;
        in_limit  = (last_byte <= lim_ext);
        hi_addr   = base_sel + AW'({sel.index, 3'b100});
    end
endmodule

// File: rtl/dru_rights_eval.sv
module dru_rights_eval
    import dru_pkg::*;
(
    input  dru_hidw_t   dw,
    input  logic [1:0]  cpl,
    input  logic [1:0]  rpl,
    input  logic        op32,
    output logic        ok,
    output logic [31:0] rights
);
    logic kind_ok;
    logic priv_ok;

    always_comb begin
        kind_ok = dw.s || sys_kind_ok(dw.kind);
        priv_ok = is_conforming(dw) || ((cpl <= dw.dpl) && (rpl <= dw.dpl));
        ok      = kind_ok && priv_ok;
        rights  = 32'(dw) & (op32 ? RIGHTS_MASK_32 : RIGHTS_MASK_16);
    end
endmodule

// File: rtl/desc_rights_unit.sv
module desc_rights_unit
    import dru_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [15:0]   sel,
    input  logic [1:0]    cpl,
    input  logic          op32,
    input  logic          prot_mode,
    input  logic [AW-1:0] gdt_base,
    input  logic [LW-1:0] gdt_limit,
    input  logic [AW-1:0] ldt_base,
    input  logic [LW-1:0] ldt_limit,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_valid,
    input  logic [31:0]   mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          zf,
    output logic          wr_en,
    output logic [31:0]   rights,
    output logic          ud_err
);
    dru_state_e    state_q;
    dru_sel_t      sel_q;
    logic [1:0]    cpl_q;
    logic          op32_q;
    logic          pm_q;
    logic          ud_q;
    logic [AW-1:0] gbase_q, lbase_q, addr_q;
    logic [LW-1:0] glim_q, llim_q;
    dru_hidw_t     dw_q;

    logic          sel_null, sel_inlim;
    logic [AW-1:0] sel_addr;
    logic          eval_ok;
    logic [31:0]   eval_rights;

    dru_sel_decode #(.AW(AW), .LW(LW)) u_dec (
        .sel       (sel_q),
        .gdt_base  (gbase_q),
        .gdt_limit (glim_q),
        .ldt_base  (lbase_q),
        .ldt_limit (llim_q),
        .is_null   (sel_null),
        .in_limit  (sel_inlim),
        .hi_addr   (sel_addr)
    );

    dru_rights_eval u_eval (
        .dw     (dw_q),
        .cpl    (cpl_q),
        .rpl    (sel_q.rpl),
        .op32   (op32_q),
        .ok     (eval_ok),
        .rights (eval_rights)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
            cpl_q   <= '0;
            op32_q  <= 1'b0;
            pm_q    <= 1'b0;
            ud_q    <= 1'b0;
            gbase_q <= '0;
            lbase_q <= '0;
            glim_q  <= '0;
            llim_q  <= '0;
            addr_q  <= '0;
            dw_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        sel_q   <= dru_sel_t'(sel);
                        cpl_q   <= cpl;
                        op32_q  <= op32;
                        pm_q    <= prot_mode;
                        gbase_q <= gdt_base;
                        lbase_q <= ldt_base;
                        glim_q  <= gdt_limit;
                        llim_q  <= ldt_limit;
                        state_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    ud_q   <= !pm_q;
                    addr_q <= sel_addr;
                    if (!pm_q || sel_null || !sel_inlim) state_q <= ST_DONE;
                    else                                   state_q <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (mem_valid) begin
                        dw_q    <= dru_hidw_t'(mem_rdata);
                        state_q <= ST_EVAL;
                    end
                end
                ST_EVAL:  state_q <= ST_IDLE;
                ST_DONE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    logic success;
    assign success  = (state_q == ST_EVAL) && eval_ok;

    assign busy     = (state_q != ST_IDLE);
    assign mem_req  = (state_q == ST_FETCH);
    assign mem_addr = addr_q;
    assign done     = (state_q == ST_EVAL) || (state_q == ST_DONE);
    assign zf       = success;
    assign wr_en    = success;
    assign rights   = success ? eval_rights : 32'h0;
    assign ud_err   = (state_q == ST_DONE) && ud_q;

endmodule

// File: rtl/dru_checker.sv
module dru_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_valid,
    input logic          busy,
    input logic          done,
    input logic          zf,
    input logic          wr_en,
    input logic [31:0]   rights,
    input logic          ud_err
);
    p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

    p_done_after_valid_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_valid |=> done);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_req_busy_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    p_flag_outside_done_r9: assert property (@(posedge clk) disable iff (rst)
        !done |-> !zf && !wr_en && !ud_err);

    p_fail_no_rights_r9: assert property (@(posedge clk) disable iff (rst)
        done && !wr_en |-> rights == 32'h0);

    p_mask_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (rights & ~32'h00F0_FF00) == 32'h0);

    p_ud_fails_r2: assert property (@(posedge clk) disable iff (rst)
        ud_err |-> !zf && !wr_en);
endmodule

bind desc_rights_unit dru_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_valid (mem_valid),
    .busy      (busy),
    .done      (done),
    .zf        (zf),
    .wr_en     (wr_en),
    .rights    (rights),
    .ud_err    (ud_err)
);

// File: tb/desc_rights_unit_tb.sv
module desc_rights_unit_tb;
    localparam int AW = 32;
    localparam int LW = 16;
    localparam logic [AW-1:0] GB = 32'h0000_1000;
    localparam logic [AW-1:0] LB = 32'h0000_8000;
    localparam logic [LW-1:0] GL = 16'h003F;
    localparam logic [LW-1:0] LL = 16'h001F;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [15:0] sel = '0;
    logic [1:0] cpl = '0;
    logic op32 = 1'b0;
    logic prot_mode = 1'b1;
    logic mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic mem_req, busy, done, zf, wr_en, ud_err;
    logic [AW-1:0] mem_addr;
    logic [31:0] rights;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    desc_rights_unit #(.AW(AW), .LW(LW)) u_dut (
        .clk(clk), .rst(rst), .start(start), .sel(sel), .cpl(cpl), .op32(op32),
        .prot_mode(prot_mode), .gdt_base(GB), .gdt_limit(GL), .ldt_base(LB),
        .ldt_limit(LL), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .zf(zf), .wr_en(wr_en), .rights(rights), .ud_err(ud_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // expected outcome computed from the requirements
    function automatic logic [32:0] model(input logic [15:0] s, input logic [1:0] c,
                                          input logic o32, input logic [31:0] d);
        logic [3:0] kind;
        logic [1:0] dpl;
        logic sbit, kind_ok, conf, pass;
        kind = d[11:8];
        dpl  = d[14:13];
        sbit = d[12];
        kind_ok = sbit || (kind inside {4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h9, 4'hB, 4'hC});
        conf = sbit && kind[3] && kind[2];
        pass = kind_ok && (conf || (c <= dpl && s[1:0] <= dpl));
        return {pass, pass ? (d & (o32 ? 32'h00F0_FF00 : 32'h0000_FF00)) : 32'h0};
    endfunction

    // runs one operation; checks table-level outcome and, if fetched, the result
    task automatic run_op(input logic [15:0] s, input logic [1:0] c, input logic o32,
                          input logic pm, input logic [31:0] d, input int lat,
                          input logic poke_start);
        logic [12:0] idx;
        logic [16:0] last;
        logic [AW-1:0] exp_addr;
        logic early_fail, fetched;
        logic [32:0] m;
        idx  = s[15:3];
        last = {1'b0, idx, 3'b111};
        exp_addr = (s[2] ? LB : GB) + AW'({idx, 3'b100});
        early_fail = !pm || (idx == 0 && !s[2]) || (last > 17'(s[2] ? LL : GL));
        fetched = 1'b0;
        @(negedge clk);
        sel = s; cpl = c; op32 = o32; prot_mode = pm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        sel = ~s;
        @(negedge clk);
        if (early_fail) begin
            chk(pm ? "R3/R4 early done" : "R2 done", 32'(done), 32'd1);
            chk("R2 ud_err", 32'(ud_err), 32'(!pm));
            chk("R3/R4 zf", 32'(zf), 32'd0);
            chk("R3/R4 no req", 32'(mem_req), 32'd0);
        end else begin
            chk("R4 req", 32'(mem_req), 32'd1);
            chk("R4 addr", mem_addr, exp_addr);
            fetched = 1'b1;
            if (poke_start) begin
                sel = 16'h0000; start = 1'b1;
            end
            for (int i = 0; i < lat; i++) begin
                @(negedge clk);
                start = 1'b0;
                chk("R10 req held", 32'(mem_req), 32'd1);
                chk("R10 addr stable", mem_addr, exp_addr);
                chk("R10 no early done", 32'(done), 32'd0);
            end
            start = 1'b0;
            mem_valid = 1'b1; mem_rdata = d;
            @(negedge clk);
            mem_valid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
            m = model(s, c, o32, d);
            chk("R10 done after valid", 32'(done), 32'd1);
            chk(m[32] ? "R9 zf pass" : "R5/R6 zf fail", 32'(zf), 32'(m[32]));
            chk("R9 wr_en", 32'(wr_en), 32'(m[32]));
            chk(o32 ? "R7 rights" : "R8 rights", rights, m[31:0]);
            chk("R2 no ud", 32'(ud_err), 32'd0);
        end
        @(negedge clk);
        chk("R10 done pulse", 32'(done), 32'd0);
        if (poke_start && fetched) chk("R10 start ignored when busy", 32'(busy), 32'd0);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 done", 32'(done), 0);
        chk("R1 zf", 32'(zf), 0);
        chk("R1 wr_en", 32'(wr_en), 0);
        chk("R1 ud", 32'(ud_err), 0);
        chk("R1 req", 32'(mem_req), 0);
        chk("R1 busy", 32'(busy), 0);
        rst = 1'b0;

        // selector sweep over both tables, past each limit
        for (int ti = 0; ti < 2; ti++)
            for (int ix = 0; ix < 10; ix++)
                run_op({13'(ix), 1'(ti), 2'd1}, 2'd0, 1'b1, 1'b1, 32'h12CB_F300, ix % 3, 1'b0);

        // type / privilege / size sweep
        for (int k = 0; k < 16; k++)
            for (int sb = 0; sb < 2; sb++)
                for (int dp = 0; dp < 4; dp++)
                    for (int c = 0; c < 4; c++)
                        for (int r = 0; r < 4; r++)
                            run_op({13'd2, 1'b0, 2'(r)}, 2'(c), 1'((k + dp + c + r) % 2), 1'b1,
                                   {8'h5A, 4'b1101, 4'hB, 1'b1, 2'(dp), 1'(sb), 4'(k), 8'hC3},
                                   (k + r) % 3, 1'b0);

        // not protected mode, including a null selector
        run_op(16'h0000, 2'd0, 1'b1, 1'b0, 32'h00CF_9300, 0, 1'b0);
        run_op(16'h0010, 2'd3, 1'b0, 1'b0, 32'h00CF_9300, 0, 1'b0);
        run_op(16'h0004, 2'd0, 1'b1, 1'b0, 32'h00CF_9300, 0, 1'b0);

        // start while busy is ignored
        run_op(16'h0018, 2'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, 2, 1'b1);
        run_op(16'h000C, 2'd0, 1'b0, 1'b1, 32'h0040_9A00, 1, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule